// File: doc/BRIEF.md
# Serial Line Decoder: NRZI Removal and Self-Synchronizing Descrambling

This block sits behind a clock-recovery front end and removes the two layers of line coding carried by a serial digital video bit stream. Each recovered line bit arrives with a valid strobe on the bit clock. A first stage turns the transition-coded stream back into level-coded bits. A second stage removes the scrambling with a self-synchronizing descrambler. That descrambler keeps a 9-bit history of received scrambled bits and inverts the generator polynomial x^9 + x^4 + 1.

Each stage has an active-high enable. A disabled stage forwards its input bit unchanged, but it still updates its history. The decoded bit leaves the block with a matching valid strobe exactly two clocks after the line bit entered, whatever the enables are set to. Downstream word framing can therefore use a fixed alignment. The descrambler enable is delayed by one register so that it travels with its bit. Both enables are therefore taken at the cycle in which the line bit is presented.

Top module: `sdv_line_decoder`

## Requirements
- R1: While rst_ni is low, bit_o and bit_vld_o are 0. The line-bit history and the 9-bit descrambler history are cleared to zero, so the first bits after reset are decoded as if all earlier line and scrambled bits were 0.
- R2: With nrzi_en_i high, the transition decoder produces 1 when the accepted line bit differs from the previously accepted line bit, and 0 when the two are equal.
- R3: With nrzi_en_i low, the accepted line bit passes through the first stage unchanged.
- R4: With desc_en_i high, the output bit is s XOR h[9] XOR h[4]. Here s is the bit arriving from the first stage, and h[k] is the k-th most recent earlier bit that arrived from the first stage.
- R5: With desc_en_i low, the bit arriving from the first stage passes to bit_o unchanged.
- R6: The transition decoding is undone before the descrambling. Every accepted input bit appears on bit_o with bit_vld_o high exactly 2 clocks after it was presented with bit_vld_i high. bit_vld_o is high in no other cycle. The latency does not depend on the enables.
- R7: With both stages enabled, the block decodes a stream that was scrambled and then transition-coded from an arbitrary unknown encoder state. Correct output starts at the 11th accepted bit, without reset or seeding.
- R8: Cycles with bit_vld_i low are ignored. bit_i is not looked at, both histories hold their values, and bit_o keeps its last value while bit_vld_o is low.
- R9: Both histories advance on every accepted bit even while their stage is disabled. A stage that is re-enabled mid-stream therefore decodes correctly at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered serial bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bit_i | input | 1 | Recovered line bit |
| bit_vld_i | input | 1 | bit_i holds a valid line bit this cycle |
| nrzi_en_i | input | 1 | Enable transition (NRZI) decoding |
| desc_en_i | input | 1 | Enable descrambling |
| bit_o | output | 1 | Decoded bit |
| bit_vld_o | output | 1 | bit_o holds a decoded bit this cycle |

## Verification
The assertions assume that bit_vld_i and both enables are settled well before each rising bit clock edge. They also assume that reset is held for at least one edge before data flows, because the latency and bypass checks count edges from the end of reset. The bench drives every input on the falling edge and releases reset only after several clocks. It changes the enables only together with a bit, which is the condition under which R9 promises correct output. For the self-synchronization case, the bench builds its encoder with a random history and leaves the first ten outputs unchecked, which is the window R7 allows.

// File: rtl/sdv_dec_pkg.sv
package sdv_dec_pkg;
  localparam int unsigned SR_LEN_DEF = 9;
  localparam int unsigned SR_TAP_DEF = 4;
  localparam int unsigned PIPE_LAT   = 2;
endpackage

// File: rtl/sdv_nrzi_stage.sv
module sdv_nrzi_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic vld_i,
  input  logic en_i,
  output logic bit_o,
  output logic vld_o
);
  logic prev_q, out_q, vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      out_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        prev_q <= bit_i;  // history tracks the line even when bypassed
        out_q  <= en_i ? (bit_i ^ prev_q) : bit_i;
      end
    end
  end

  assign bit_o = out_q;
  assign vld_o = vld_q;

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(prev_q) && $stable(out_q));
endmodule

// File: rtl/sdv_descram_stage.sv
module sdv_descram_stage #(
  parameter int unsigned SR_LEN = sdv_dec_pkg::SR_LEN_DEF,
  parameter int unsigned SR_TAP = sdv_dec_pkg::SR_TAP_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic vld_i,
  input  logic en_i,
  output logic bit_o,
  output logic vld_o
);
  localparam int unsigned HI = SR_LEN - 1;
  localparam int unsigned LO = SR_TAP - 1;

  logic [HI:0] sr_q;
  logic        out_q, vld_q, fb;

  assign fb = sr_q[HI] ^ sr_q[LO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      out_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (vld_i) begin
        sr_q  <= {sr_q[HI-1:0], bit_i};  // scrambled bit enters history
        out_q <= en_i ? (bit_i ^ fb) : bit_i;
      end
    end
  end

  assign bit_o = out_q;
  assign vld_o = vld_q;

  assert_hist_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> sr_q[0] == $past(bit_i));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(sr_q) && $stable(out_q));
endmodule

// File: rtl/sdv_line_decoder.sv
module sdv_line_decoder #(
  parameter int unsigned SR_LEN = sdv_dec_pkg::SR_LEN_DEF,
  parameter int unsigned SR_TAP = sdv_dec_pkg::SR_TAP_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_vld_i,
  input  logic nrzi_en_i,
  input  logic desc_en_i,
  output logic bit_o,
  output logic bit_vld_o
);
  logic mid_bit, mid_vld, desc_en_q;

  // enable rides one stage with its bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) desc_en_q <= 1'b0;
    else         desc_en_q <= desc_en_i;
  end

  sdv_nrzi_stage u_nrzi (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_i (bit_i),
    .vld_i (bit_vld_i),
    .en_i  (nrzi_en_i),
    .bit_o (mid_bit),
    .vld_o (mid_vld)
  );

  sdv_descram_stage #(.SR_LEN(SR_LEN), .SR_TAP(SR_TAP)) u_desc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bit_i (mid_bit),
    .vld_i (mid_vld),
    .en_i  (desc_en_q),
    .bit_o (bit_o),
    .vld_o (bit_vld_o)
  );

  // edges since reset release, saturating, for the 2-deep lookback
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) assert_reset_R1: assert (!bit_o && !bit_vld_o);
  end

  assert_lat_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q >= 2'd2 |-> bit_vld_o == $past(bit_vld_i, 2));
  assert_bypass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2) && bit_vld_o && $past(!nrzi_en_i && !desc_en_i && bit_vld_i, 2)
      |-> bit_o == $past(bit_i, 2));
  assert_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_o && (warm_q >= 2'd1) |-> $stable(bit_o));
endmodule

// File: tb/sim_sdv_line_decoder.sv
module sim_sdv_line_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_in = 1'b0, vld_in = 1'b0, nen = 1'b0, den = 1'b0;
  logic bit_out, vld_out;

  always #10 clk = ~clk;

  sdv_line_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_in), .bit_vld_i(vld_in),
    .nrzi_en_i(nen), .desc_en_i(den), .bit_o(bit_out), .bit_vld_o(vld_out)
  );

  int checks = 0, errors = 0;
  string req = "R1";
  logic [8:0] enc_sr;
  logic line_q;
  logic [1:0] vh;
  logic exp_q[$];
  int skip;
  logic last_out;

  task automatic chk(string r, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", r, act, exp, $time);
    end
  endtask

  // one cycle: check outputs from two drives ago, then drive new inputs
  task automatic step(logic v, logic d, logic ne, logic de);
    logic x, feed;
    @(negedge clk);
    chk("R6", vld_out, vh[1]);
    if (vld_out && exp_q.size() > 0) begin
      logic e;
      e = exp_q.pop_front();
      if (skip > 0) skip--;
      else chk(req, bit_out, e);
      last_out = bit_out;
    end else if (!vld_out && vh[1] == 1'b0 && checks > 0) begin
      chk("R8", bit_out, last_out);
    end
    vh = {vh[0], v};
    vld_in = v; nen = ne; den = de;
    if (v) begin
      x = de ? (d ^ enc_sr[8] ^ enc_sr[3]) : d;
      enc_sr = {enc_sr[7:0], x};
      feed = ne ? (line_q ^ x) : x;
      line_q = feed;
      bit_in = feed;
      exp_q.push_back(d);
    end else begin
      bit_in = 1'($urandom);  // must be ignored
    end
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, nen, den);
    chk("R6", 1'(exp_q.size() == 0), 1'b1);
    exp_q.delete();
  endtask

  task automatic t_reset();
    req = "R1";
    @(negedge clk);
    chk("R1", bit_out, 1'b0);
    chk("R1", vld_out, 1'b0);
    rst_n = 1'b1;
    enc_sr = '0; line_q = 1'b0;
    // zero-history decode of first bits after reset
    for (int i = 0; i < 12; i++) step(1'b1, 1'($urandom), 1'b1, 1'b1);
    flush();
  endtask

  task automatic t_mode(string r, logic ne, logic de, int n);
    req = r;
    for (int i = 0; i < n; i++) step(1'b1, 1'($urandom), ne, de);
    flush();
  endtask

  task automatic t_pattern();
    req = "R2";
    for (int i = 0; i < 24; i++) step(1'b1, 1'(i % 3 == 0), 1'b1, 1'b0);
    for (int i = 0; i < 24; i++) step(1'b1, 1'b1, 1'b1, 1'b1);
    req = "R4";
    for (int i = 0; i < 24; i++) step(1'b1, 1'b0, 1'b1, 1'b1);
    flush();
  endtask

  task automatic t_gaps();
    req = "R8";
    for (int i = 0; i < 80; i++) begin
      if ($urandom % 3 == 0) step(1'b0, 1'b0, 1'b1, 1'b1);
      else step(1'b1, 1'($urandom), 1'b1, 1'b1);
    end
    flush();
  endtask

  task automatic t_toggle();
    req = "R9";
    for (int i = 0; i < 120; i++)
      step(1'b1, 1'($urandom), 1'(i % 7 != 0), 1'(i % 5 != 0));
    flush();
  endtask

  task automatic t_selfsync();
    req = "R7";
    enc_sr = 9'($urandom);
    line_q = ~bit_out;
    skip = 10;
    for (int i = 0; i < 60; i++) step(1'b1, 1'($urandom), 1'b1, 1'b1);
    flush();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vh = '0; skip = 0; last_out = 1'b0;
    enc_sr = '0; line_q = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_mode("R3", 1'b0, 1'b0, 40);
    t_mode("R5", 1'b1, 1'b0, 40);
    t_mode("R4", 1'b0, 1'b1, 40);
    t_mode("R6", 1'b1, 1'b1, 60);
    t_pattern();
    t_gaps();
    t_toggle();
    t_selfsync();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule